// File: doc/BRIEF.md
# Capacitor Mismatch Calibration Sequencer

This block drives the self-calibration pass that a successive-approximation converter runs before it converts in normal operation. It works through the capacitive bits of the main DAC one at a time, starting with the most significant. Each bit gets two steps. In the sample step, the correction sub-DAC sits at mid-code and the comparator inputs rest at common mode. In the conversion step, the bit under test is flipped to the opposite reference. A binary search on the 7-bit correction code then measures the charge imbalance that the flip leaves behind.

The measured code is turned into a signed offset from mid-code. The error already assigned to the higher bits is removed from this offset. The remainder is halved and stored as that bit's correction term. A running signed sum of the stored terms makes the subtraction a single step per bit. The terms stay visible on an output bus for the conversion engine and for inspection. A done pulse marks the end of the pass, and a valid flag then holds until the next pass starts.

Top module: `cal_seq`

## Requirements
- R1: After reset the outputs are as follows: sub-DAC code 64, no bit selected, sample flag low, all error entries zero, done low and valid low.
- R2: A start pulse while idle gives, on the next cycle, a sample step on the top capacitive bit. In that cycle `bit_sel_o[NCAP-1]` is high, the sample flag is high and the code is 64. The same start clears every error entry and the valid flag.
- R3: During a sample step the code is 64. An advance strobe ends the sample step and begins the conversion step with 64 as the first trial. Each later advance strobe resolves the current trial bit, MSB first. A comparator value of 1 keeps the bit, where 1 means the trial code is not above the target. A value of 0 clears the bit. The next lower bit is then set. Seven strobes resolve the found code X.
- R4: Bits are handled strictly from `bit_sel_o[NCAP-1]` down to `bit_sel_o[0]`. Each bit has its own sample step, and at most one select is high at a time.
- R5: When bit k finishes, entry k of `err_o` (bits [8k+7:8k], two's complement) becomes DV = (D - S)/2. Here D = X - 64, and S is the sum of the DV values stored earlier in the same pass.
- R6: The halving rounds halves away from zero. For example, a difference of +3 gives +2, -5 gives -3, and an even difference is halved exactly.
- R7: `done_o` is high for exactly one cycle, the cycle after the last entry is stored. `cal_valid_o` rises in that same cycle and stays high until the next start.
- R8: A start pulse during a pass has no effect. Advance strobes while idle have no effect on the selects, the code, the entries or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration pass |
| advance_i | input | 1 | Step strobe: ends the sample step, or validates the comparator for one trial |
| cmp_i | input | 1 | Comparator result, 1 = keep trial bit |
| subdac_o | output | CW | Correction sub-DAC code |
| bit_sel_o | output | NCAP | One-hot select of the capacitive bit under test |
| sample_o | output | 1 | High during the sample step (comparator at common mode) |
| err_o | output | NCAP*EW | Per-bit signed error terms, entry k at [EW*k +: EW] |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| cal_valid_o | output | 1 | Error terms are complete and valid |

## Verification
Each result is registered once, so every response shows at the first clock edge after its cause. A start moves to the top-bit sample step one edge later. Each advance strobe moves the code one edge later. The seventh trial strobe of a bit both writes that bit's entry and moves on to the next sample step at the same edge. The done pulse follows the last bit's seventh strobe by one edge. The bench drives inputs on the falling edge and reads outputs on the following falling edge, half a period after the edge that produced them. Its reference model advances in that same rhythm, so every comparison sees a settled value.

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int NCAP = 8,
  parameter int CW   = 7,
  parameter int EW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                advance_i,
  input  logic                cmp_i,
  output logic [CW-1:0]       subdac_o,
  output logic [NCAP-1:0]     bit_sel_o,
  output logic                sample_o,
  output logic [NCAP*EW-1:0]  err_o,
  output logic                done_o,
  output logic                cal_valid_o
);
  localparam int AW = CW + 2;
  localparam int IW = (NCAP > 1) ? $clog2(NCAP) : 1;
  localparam int TW = (CW > 1) ? $clog2(CW) : 1;
  localparam logic [CW-1:0] MID = CW'(1) << (CW - 1);
  localparam logic [AW-1:0] MID_W = {2'b00, MID};
  localparam logic signed [AW-1:0] ONE = 1;

  typedef enum logic [1:0] {IDLE, SAMP, CONV} state_t;

  state_t                   state;
  logic [IW-1:0]            idx;
  logic [TW-1:0]            trial;
  logic [CW-1:0]            code;
  logic signed [AW-1:0]     acc;
  logic [NCAP*EW-1:0]       err_q;
  logic                     done_q, valid_q;

  logic [CW-1:0]            trial_mask, resolved;
  logic                     last_trial, store;
  logic signed [AW-1:0]     offset, diff, diff_adj, half;

  assign trial_mask = CW'(1) << trial;
  assign resolved   = cmp_i ? code : (code & ~trial_mask);
  assign last_trial = (trial == '0);
  assign store      = (state == CONV) && advance_i && last_trial;

  assign offset   = $signed({2'b00, resolved}) - $signed(MID_W);
  assign diff     = offset - acc;
  assign diff_adj = !diff[0] ? diff : (diff[AW-1] ? diff - ONE : diff + ONE);
  assign half     = diff_adj >>> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      idx     <= '0;
      trial   <= '0;
      code    <= MID;
      acc     <= '0;
      err_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        IDLE: if (start_i) begin
          state   <= SAMP;
          idx     <= IW'(NCAP - 1);
          code    <= MID;
          acc     <= '0;
          err_q   <= '0;
          valid_q <= 1'b0;
        end
        SAMP: begin
          code <= MID;
          if (advance_i) begin
            state <= CONV;
            trial <= TW'(CW - 1);
          end
        end
        CONV: if (advance_i) begin
          if (!last_trial) begin
            code  <= resolved | (trial_mask >> 1);
            trial <= trial - TW'(1);
          end else begin
            code <= MID;
            acc  <= acc + half;
            err_q[idx*EW +: EW] <= half[EW-1:0];
            if (idx == '0) begin
              state   <= IDLE;
              done_q  <= 1'b1;
              valid_q <= 1'b1;
            end else begin
              idx   <= idx - IW'(1);
              state <= SAMP;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign subdac_o    = code;
  assign bit_sel_o   = (state == IDLE) ? '0 : (NCAP'(1) << idx);
  assign sample_o    = (state == SAMP);
  assign err_o       = err_q;
  assign done_o      = done_q;
  assign cal_valid_o = valid_q;

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bit_sel_o));

  assert_sample_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (subdac_o == MID));

  assert_start_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && start_i) |=> (sample_o && bit_sel_o[NCAP-1] && !cal_valid_o && err_o == '0));

  assert_done_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cal_valid_o && bit_sel_o == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SAMP && start_i) |=> (bit_sel_o == $past(bit_sel_o)));

  assert_idle_advance_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && !start_i) |=> (!sample_o && bit_sel_o == '0 && $stable(err_o)));

  assert_store_moves_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (store && idx != '0) |=> (sample_o && bit_sel_o == ($past(bit_sel_o) >> 1)));
endmodule

// File: tb/cal_seq_tb.sv
module cal_seq_tb;
  localparam int NCAP = 8;
  localparam int CW   = 7;
  localparam int EW   = 8;
  localparam int NV   = 7;

  // targets listed top bit first; the last one exercises R6 rounding
  localparam logic [NCAP*CW-1:0] VECS [NV] = '{
    {7'd64, 7'd64, 7'd64, 7'd64, 7'd64, 7'd64, 7'd64, 7'd64},
    {7'd127,7'd127,7'd127,7'd127,7'd127,7'd127,7'd127,7'd127},
    {7'd0,  7'd0,  7'd0,  7'd0,  7'd0,  7'd0,  7'd0,  7'd0},
    {7'd100,7'd30, 7'd64, 7'd65, 7'd63, 7'd90, 7'd10, 7'd77},
    {7'd65, 7'd63, 7'd66, 7'd62, 7'd64, 7'd64, 7'd127,7'd0},
    {7'd1,  7'd126,7'd2,  7'd125,7'd3,  7'd124,7'd4,  7'd123},
    {7'd67, 7'd61, 7'd70, 7'd55, 7'd64, 7'd63, 7'd66, 7'd59}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic advance_i = 1'b0;
  logic cmp_i = 1'b0;
  logic [CW-1:0] subdac_o;
  logic [NCAP-1:0] bit_sel_o;
  logic sample_o;
  logic [NCAP*EW-1:0] err_o;
  logic done_o;
  logic cal_valid_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cal_seq #(.NCAP(NCAP), .CW(CW), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .advance_i(advance_i),
    .cmp_i(cmp_i), .subdac_o(subdac_o), .bit_sel_o(bit_sel_o),
    .sample_o(sample_o), .err_o(err_o), .done_o(done_o),
    .cal_valid_o(cal_valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int entry(input int k);
    logic signed [EW-1:0] v;
    v = err_o[k*EW +: EW];
    return int'(v);
  endfunction

  task automatic run_cal(input logic [NCAP*CW-1:0] vec, input bit noisy);
    int acc;
    int code;
    int x;
    int d;
    int df;
    int dv;
    bit c;
    acc = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = noisy;
    chk(cal_valid_o == 1'b0, "R2 valid cleared", cal_valid_o, 0);
    chk(err_o == '0, "R2 entries cleared", (err_o != '0), 0);
    for (int k = NCAP - 1; k >= 0; k--) begin
      x = int'(vec[k*CW +: CW]);
      chk(sample_o && bit_sel_o == (NCAP'(1) << k), "R4 sample step select",
          int'(bit_sel_o), 1 << k);
      chk(subdac_o == 7'd64, "R3 sample code", int'(subdac_o), 64);
      advance_i = 1'b1;
      @(negedge clk);
      code = 64;
      for (int t = CW - 1; t >= 0; t--) begin
        chk(subdac_o == CW'(code) && !sample_o, "R3 trial code", int'(subdac_o), code);
        c = (code <= x);
        cmp_i = c;
        @(negedge clk);
        if (!c) code = code & ~(1 << t);
        if (t > 0) code = code | (1 << (t - 1));
      end
      d = code - 64;
      df = d - acc;
      dv = (df >= 0) ? (df + 1) / 2 : -((-df + 1) / 2);
      acc = acc + dv;
      chk(entry(k) == dv, "R5 R6 stored error", entry(k), dv);
    end
    chk(done_o == 1'b1 && cal_valid_o == 1'b1, "R7 done and valid", {done_o, cal_valid_o}, 3);
    chk(bit_sel_o == '0, "R4 no select after pass", int'(bit_sel_o), 0);
    advance_i = 1'b0;
    start_i = 1'b0;
    cmp_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0 && cal_valid_o == 1'b1, "R7 done pulse ends, valid held",
        {done_o, cal_valid_o}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NCAP*EW-1:0] saved;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(subdac_o == 7'd64, "R1 reset code", int'(subdac_o), 64);
    chk(bit_sel_o == '0 && !sample_o, "R1 reset select", int'(bit_sel_o), 0);
    chk(err_o == '0, "R1 reset entries", (err_o != '0), 0);
    chk(!done_o && !cal_valid_o, "R1 reset flags", {done_o, cal_valid_o}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) run_cal(VECS[v], 1'b0);

    // R8: start held high during the whole pass
    run_cal(VECS[3], 1'b1);

    // R8: advance strobes while idle
    saved = err_o;
    advance_i = 1'b1;
    cmp_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(bit_sel_o == '0 && !sample_o, "R8 idle advance select", int'(bit_sel_o), 0);
    chk(err_o == saved, "R8 idle advance entries", (err_o != saved), 0);
    chk(cal_valid_o && !done_o && subdac_o == 7'd64, "R8 idle advance flags",
        {cal_valid_o, done_o}, 2);
    advance_i = 1'b0;
    cmp_i = 1'b0;

    // R2: a new pass clears the previous results
    run_cal(VECS[0], 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule